// File: doc/BRIEF.md
# Register-Mapped Return Address Stack

This block is a last-in first-out store of 32-bit return addresses for a small processor. The processor reaches it through one architectural register index, the link index (1), rather than through dedicated instructions. When the register file writes the link index, the written value is pushed. When it reads the link index, the top address is returned on the read port in the same cycle and removed at the next clock edge.

The block also provides the hard-wired zero behaviour of register index 0. It raises claim outputs so that the surrounding register file knows when to use the block's read data and when to drop its own write. An illegal access produces a one-cycle alert, which the surrounding logic can route to its error handling. The two illegal accesses are a pop from an empty stack and a push onto a full one. Fill count, empty and full are visible at the ports.

Top module: `reg_link_stack`

## Requirements
- R1: After reset the stack is empty: `fillCount` is 0, `empty` is 1, `full` is 0 and `alert` is 0.
- R2: A cycle with `wrEn` high and `wrIdx` equal to 1 pushes `wrData`. On the next cycle `fillCount` is one higher and reading index 1 returns that value.
- R3: While `rdIdx` is 1 and the stack is not empty, `rdData` shows the top entry combinationally in the same cycle. If `rdEn` is also high, that entry is removed at the clock edge, so successive pops return entries in reverse order of pushing.
- R4: A read of index 1 with `rdEn` high while the stack is empty returns 0 on `rdData`, raises `alert` in the following cycle and leaves `fillCount` unchanged.
- R5: Index 0 always reads 0 with `rdClaim` high. A write to index 0 changes neither the count nor any stored entry.
- R6: A push with no accompanying pop while the stack holds DEPTH entries raises `alert` in the following cycle and leaves the count and all stored entries unchanged.
- R7: A push and a pop of index 1 in the same cycle on a non-empty stack return the old top on `rdData`. The pushed value becomes the new top and `fillCount` is unchanged.
- R8: A push and a pop in the same cycle on an empty stack raise `alert` for the underflowing pop. The push still completes, leaving one entry holding the pushed value.
- R9: `empty` is 1 exactly when `fillCount` is 0, and `full` is 1 exactly when `fillCount` equals DEPTH (8 by default).
- R10: Indices 2 to 31 are not handled by this block. For them `rdClaim` and `wrClaim` are 0, `rdData` is 0, and reads or writes leave the stack unchanged. For indices 0 and 1 the claim outputs are 1.
- R11: `alert` is high only in the cycle after an illegal access and returns to 0 after any cycle with no illegal access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Register read is being consumed this cycle |
| rdIdx | input | 5 | Register index being read |
| rdData | output | 32 | Read data for index 0 or 1, otherwise 0 |
| rdClaim | output | 1 | Read index belongs to this block |
| wrEn | input | 1 | Register write this cycle |
| wrIdx | input | 5 | Register index being written |
| wrData | input | 32 | Write data |
| wrClaim | output | 1 | Write index belongs to this block |
| alert | output | 1 | One-cycle pulse after an underflow or overflow |
| empty | output | 1 | Stack holds no entries |
| full | output | 1 | Stack holds DEPTH entries |
| fillCount | output | 4 | Current number of entries |

## Verification
A wrong fill count shows at once on `fillCount`, `empty` and `full` in the cycle after the faulty edge. It also surfaces as a premature or missing alert at the next boundary access. A corrupted or misordered entry stays hidden until it reaches the top. It then appears on `rdData` at index 1, possibly many cycles later, so the bench drains the stack completely after each fill and compares every popped value. Swap cycles and zero-index writes are interleaved with pops so that damage to a buried entry is exposed.

// File: rtl/rls_pkg.sv
package rls_pkg;
  // Strobes from control to storage for one clock edge
  typedef struct packed {
    logic push;   // place the write data on top
    logic pop;    // remove the current top
  } rlsStrobe_t;
endpackage

// File: rtl/rls_ctrl.sv
module rls_ctrl
  import rls_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned LINK_IDX = 1,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output rlsStrobe_t       strb,
  output logic [CNT_W-1:0] fillCount,
  output logic             alert,
  output logic             empty,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] LINK_SEL = IDX_W'(LINK_IDX);

  logic popReq, pushReq, popOk, pushOk, underflow, overflow;
  logic [CNT_W-1:0] countQ, countNext;

  assign popReq    = rdEn && (rdIdx == LINK_SEL);
  assign pushReq   = wrEn && (wrIdx == LINK_SEL);
  assign empty     = (countQ == '0);
  assign full      = (countQ == CNT_MAX);
  assign underflow = popReq && empty;
  assign popOk     = popReq && !empty;
  assign overflow  = pushReq && full && !popOk;
  assign pushOk    = pushReq && !overflow;

  always_comb begin
    countNext = countQ;
    if (pushOk && !popOk)      countNext = countQ + CNT_W'(1);
    else if (popOk && !pushOk) countNext = countQ - CNT_W'(1);
  end

  assign strb.push = pushOk;
  assign strb.pop  = popOk;
  assign fillCount = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      alert  <= 1'b0;
    end else begin
      countQ <= countNext;
      alert  <= underflow || overflow;
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_MAX); // R9
  AST_UNDERFLOW_ALERT: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty) |=> alert); // R4
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty && !pushReq) |=> $stable(fillCount)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full && !popReq) |=> (alert && fillCount == CNT_MAX)); // R6
  AST_SWAP_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !empty) |=> $stable(fillCount)); // R7
  AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!popReq && !pushReq) |=> !alert); // R11
endmodule

// File: rtl/rls_dpath.sv
module rls_dpath
  import rls_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rlsStrobe_t        strb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topData
);
  // Shift-register stack: slot 0 is always the top
  logic [DATA_W-1:0] slotQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] fromAbove, fromBelow;
    if (i == 0) begin : g_head
      assign fromAbove = pushData;
    end else begin : g_body
      assign fromAbove = slotQ[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign fromBelow = '0;
    end else begin : g_inner
      assign fromBelow = slotQ[i+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ[i] <= '0;
      end else begin
        unique case ({strb.push, strb.pop})
          2'b10: slotQ[i] <= fromAbove;
          2'b01: slotQ[i] <= fromBelow;
          2'b11: if (i == 0) slotQ[i] <= pushData;
          default: ;
        endcase
      end
    end
  end

  assign topData = slotQ[0];

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (topData == $past(pushData))); // R2
  AST_IDLE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.push && !strb.pop) |=> $stable(topData)); // R5
endmodule

// File: rtl/reg_link_stack.sv
module reg_link_stack
  import rls_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned ZERO_IDX = 0,
  parameter int unsigned LINK_IDX = 1,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdClaim,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrClaim,
  output logic              alert,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  fillCount
);
  localparam logic [IDX_W-1:0] ZERO_SEL = IDX_W'(ZERO_IDX);
  localparam logic [IDX_W-1:0] LINK_SEL = IDX_W'(LINK_IDX);

  rlsStrobe_t        strb;
  logic [DATA_W-1:0] topData;

  rls_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn),
    .wrIdx(wrIdx), .strb(strb), .fillCount(fillCount), .alert(alert),
    .empty(empty), .full(full)
  );

  rls_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(wrData), .topData(topData)
  );

  assign rdClaim = (rdIdx == ZERO_SEL) || (rdIdx == LINK_SEL);
  assign wrClaim = (wrIdx == ZERO_SEL) || (wrIdx == LINK_SEL);
  assign rdData  = (rdIdx == LINK_SEL && !empty) ? topData : '0;

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == ZERO_SEL) |-> (rdData == '0 && rdClaim)); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> (rdData == '0)); // R4
endmodule

// File: tb/reg_link_stack_tb.sv
module reg_link_stack_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [4:0]  rdIdx = '0, wrIdx = '0;
  logic [31:0] wrData = '0, rdData;
  logic        rdClaim, wrClaim, alert, empty, full;
  logic [3:0]  fillCount;

  int checks = 0, errors = 0;
  logic [31:0] mdl [DEPTH];
  int mcnt = 0;
  logic expAlert = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  reg_link_stack u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData),
    .rdClaim(rdClaim), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrClaim(wrClaim), .alert(alert), .empty(empty), .full(full),
    .fillCount(fillCount)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic chkState(input string tag);
    chk(tag, "alert", 32'(alert), 32'(expAlert));
    chk(tag, "fillCount", 32'(fillCount), 32'(mcnt));
    chk("R9", "empty", 32'(empty), 32'(mcnt == 0));
    chk("R9", "full", 32'(full), 32'(mcnt == DEPTH));
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic cyc(input string tag, input logic re, input logic [4:0] ri,
                     input logic we, input logic [4:0] wi, input logic [31:0] wd);
    logic popReq, pushReq, popOk, und, ovf;
    rdEn = re; rdIdx = ri; wrEn = we; wrIdx = wi; wrData = wd;
    #1;
    chk(tag, "rdData", rdData, (ri == 5'd1 && mcnt > 0) ? mdl[mcnt-1] : 32'd0);
    chk("R10", "rdClaim", 32'(rdClaim), 32'(ri < 5'd2));
    chk("R10", "wrClaim", 32'(wrClaim), 32'(wi < 5'd2));
    popReq  = re && ri == 5'd1;
    pushReq = we && wi == 5'd1;
    popOk   = popReq && mcnt > 0;
    und     = popReq && mcnt == 0;
    ovf     = pushReq && mcnt == DEPTH && !popOk;
    @(posedge clk);
    if (popOk) mcnt--;
    if (pushReq && !ovf) begin
      mdl[mcnt] = wd;
      mcnt++;
    end
    expAlert = und || ovf;
    @(negedge clk);
    chkState(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkState("R1");
    rstN = 1'b1;
    @(negedge clk);
    chkState("R1");

    // R10: unhandled indices
    for (int i = 2; i < 32; i++) cyc("R10", 1'b1, 5'(i), 1'b1, 5'(i), 32'hdead_0000 + 32'(i));
    // R5: zero index on empty stack
    cyc("R5", 1'b1, 5'd0, 1'b1, 5'd0, 32'hffff_ffff);

    // R2: fill completely
    for (int i = 0; i < DEPTH; i++) cyc("R2", 1'b0, 5'd1, 1'b1, 5'd1, 32'h1000_0001 * 32'(i + 1));
    // R6: overflow twice, then an idle cycle clears the alert (R11)
    cyc("R6", 1'b0, 5'd1, 1'b1, 5'd1, 32'hbad0_bad0);
    cyc("R6", 1'b0, 5'd1, 1'b1, 5'd1, 32'hbad1_bad1);
    cyc("R11", 1'b0, 5'd1, 1'b0, 5'd0, 32'd0);
    // R7: swap while full
    cyc("R7", 1'b1, 5'd1, 1'b1, 5'd1, 32'h5a5a_0007);
    // R5: zero-index write while full leaves entries intact
    cyc("R5", 1'b1, 5'd0, 1'b1, 5'd0, 32'h0bad_0bad);
    // R3: drain in LIFO order
    for (int i = 0; i < DEPTH; i++) cyc("R3", 1'b1, 5'd1, 1'b0, 5'd0, 32'd0);
    // R4: underflow twice then recover (R11)
    cyc("R4", 1'b1, 5'd1, 1'b0, 5'd0, 32'd0);
    cyc("R4", 1'b1, 5'd1, 1'b0, 5'd0, 32'd0);
    cyc("R11", 1'b0, 5'd0, 1'b0, 5'd0, 32'd0);
    // R8: swap on empty stack
    cyc("R8", 1'b1, 5'd1, 1'b1, 5'd1, 32'hc0de_0008);
    cyc("R8", 1'b0, 5'd1, 1'b0, 5'd0, 32'd0);
    // R7: swaps at depth 1 and 2
    cyc("R7", 1'b1, 5'd1, 1'b1, 5'd1, 32'hc0de_0009);
    cyc("R2", 1'b0, 5'd1, 1'b1, 5'd1, 32'hc0de_000a);
    cyc("R7", 1'b1, 5'd1, 1'b1, 5'd1, 32'hc0de_000b);
    cyc("R3", 1'b1, 5'd1, 1'b0, 5'd0, 32'd0);
    cyc("R3", 1'b1, 5'd1, 1'b0, 5'd0, 32'd0);

    // Mixed sweep over indices 0..2 and all strobe combinations
    for (int n = 0; n < 4000; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cyc("R9", lcg[20], 5'(lcg[23:22] % 3), lcg[21], 5'(lcg[26:25] % 3), lcg ^ 32'h9e37_79b9);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule